// File: doc/BRIEF.md
# Synchronous Buck Non-Overlap Gate Controller

This block is the digital control core of a half-bridge gate driver for a synchronous buck stage. It takes two three-level commands that arrive already quantised to 2-bit codes. The switching command selects which transistor conducts. The enable command switches the stage on or off, or puts it into a braking state. The block also takes a supply lockout flag and one discharge feedback bit per gate. From these it drives registered logic-level enables for the high-side and the low-side gate.

Every turn-on is break-before-make. The opposite gate is dropped first. The block then waits until that gate's discharge feedback has been seen, and then waits a further programmable number of cycles. After the driver leaves the disabled state, the switching command is ignored for a settling interval. Lockout, enable low and enable mid outrank everything else: any of them cancels a sequence that is under way and clears both enables at the next edge.

Top module: `nol_gate_ctrl`

## Requirements
- R1: A synchronous reset clears both enables and re-arms the settling interval. After reset is released with enable high and no lockout, both enables stay low for SETTLE_CYC edges, and the sequencing described below starts only after that.
- R2: While `supply_low` is 1, both enables are low from the first edge that samples it. When it drops back to 0, the settling interval of R1 runs again before any gate turns on.
- R3: Enable code 2'b00 (low) disables the driver. Both enables go low at the next edge and the settling interval is re-armed. Once enable returns to 2'b10 (high), the switching code is ignored and both enables stay low for SETTLE_CYC edges.
- R4: Enable code 2'b01 (mid) holds both enables low whatever the switching code is. The driver still counts as enabled, so returning from mid to high starts sequencing at once, with no settling interval.
- R5: With enable high and the interval settled, switching code 2'b10 (high) gives hs_on=1 and ls_on=0 in steady state. Switching code 2'b00 (low) gives hs_on=0 and ls_on=1.
- R6: On a switch to high, ls_on drops at the first edge. hs_on rises at the DLY_HS-th consecutive edge that samples `ls_dis`=1. If `ls_dis` is sampled 0, that count restarts from zero.
- R7: On a switch to low, hs_on drops at the first edge. ls_on rises at the DLY_LS-th consecutive edge that samples `hs_dis`=1, and the count restarts whenever `hs_dis` is sampled 0.
- R8: Switching code 2'b01 (mid), and the unused code 2'b11, clear both enables at the next edge and keep them low while the code stays there. A gate commanded after a mid state still waits for its feedback and its full delay.
- R9: hs_on and ls_on are never 1 in the same cycle.
- R10: A lockout, enable low or enable mid that arrives while a turn-on delay is counting cancels it, and the pending gate does not turn on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_code | input | 2 | Switching command: 00 low, 01 mid, 10 high, 11 treated as mid |
| en_code | input | 2 | Enable command: 00 low, 01 mid (braking), 10 high, 11 treated as mid |
| supply_low | input | 1 | 1 while the supply is under the lockout threshold (hysteresis applied upstream) |
| hs_dis | input | 1 | 1 when the high-side gate has discharged below its off threshold |
| ls_dis | input | 1 | 1 when the low-side gate has discharged below its off threshold |
| hs_on | output | 1 | Registered high-side gate enable |
| ls_on | output | 1 | Registered low-side gate enable |

## Verification
The bench times each turn-on against the edge at which feedback was first seen. This catches a design that skips the feedback wait or counts the delay one cycle off. It also drops the feedback partway through the count, which catches a design that keeps the partial count instead of restarting and so turns the gate on early. It pulses the switching command to mid for a single cycle and checks that the gate still waits its full delay. It also steps enable from mid back to high and expects no settling pause there, while it does expect one after enable low and after lockout. A design that mixed up these two cases would either stall in braking recovery or obey the switching command before its inputs had settled. Finally, a long random run with random feedback checks on every cycle that the two enables never overlap.

// File: rtl/nol_pkg.sv
package nol_pkg;

  typedef enum logic [1:0] {
    LV_LOW,
    LV_MID,
    LV_HIGH
  } lvl_t;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ARM_HS,
    SQ_HS,
    SQ_ARM_LS,
    SQ_LS
  } seq_t;

  // Three-level code decode; the unused code behaves as mid (both off).
  function automatic lvl_t decode_lvl(input logic [1:0] code);
    case (code)
      2'b00:   return LV_LOW;
      2'b10:   return LV_HIGH;
      default: return LV_MID;
    endcase
  endfunction

endpackage

// File: rtl/nol_input_qual.sv
module nol_input_qual
  import nol_pkg::*;
(
  input  logic [1:0] pwm_code,
  input  logic [1:0] en_code,
  input  logic       supply_low,
  output lvl_t       pwm_lvl,
  output logic       enabled,
  output logic       run
);

  lvl_t en_lvl;

  always_comb begin
    en_lvl  = decode_lvl(en_code);
    pwm_lvl = decode_lvl(pwm_code);
    // Enabled: braking or running, with the supply good.
    enabled = !supply_low && (en_lvl != LV_LOW);
    // Run: switching is allowed by the enable command.
    run     = !supply_low && (en_lvl == LV_HIGH);
  end

endmodule

// File: rtl/nol_blank.sv
module nol_blank #(
  parameter int SETTLE_CYC = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic enabled,
  output logic ready
);

  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYC);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst || !enabled) begin
      remain <= LOAD;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign ready = (remain == '0);

  // R2
  blank_rearm_chk: assert property (@(posedge clk) disable iff (rst)
    !enabled |=> !ready);

  // R4
  blank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && enabled) |=> ready);

endmodule

// File: rtl/nol_seq.sv
module nol_seq
  import nol_pkg::*;
#(
  parameter int DLY_HS = 4,
  parameter int DLY_LS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  lvl_t pwm_lvl,
  input  logic hs_dis,
  input  logic ls_dis,
  output logic hs_on,
  output logic ls_on
);

  localparam int DMAX = (DLY_HS > DLY_LS) ? DLY_HS : DLY_LS;
  localparam int CW   = $clog2(DMAX + 1);
  localparam logic [CW-1:0] HS_LAST = CW'(DLY_HS - 1);
  localparam logic [CW-1:0] LS_LAST = CW'(DLY_LS - 1);

  seq_t          st;
  logic [CW-1:0] cnt;

  // Target state when no gate is on: arm the commanded side, else idle.
  function automatic seq_t arm_for(input lvl_t lv);
    case (lv)
      LV_HIGH: return SQ_ARM_HS;
      LV_LOW:  return SQ_ARM_LS;
      default: return SQ_IDLE;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst || !go) begin
      st    <= SQ_IDLE;
      cnt   <= '0;
      hs_on <= 1'b0;
      ls_on <= 1'b0;
    end else begin
      case (st)
        SQ_IDLE: begin
          st  <= arm_for(pwm_lvl);
          cnt <= '0;
        end
        SQ_ARM_HS: begin
          if (pwm_lvl != LV_HIGH) begin
            st  <= arm_for(pwm_lvl);
            cnt <= '0;
          end else if (!ls_dis) begin
            cnt <= '0;
          end else if (cnt == HS_LAST) begin
            st    <= SQ_HS;
            cnt   <= '0;
            hs_on <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SQ_HS: begin
          if (pwm_lvl != LV_HIGH) begin
            hs_on <= 1'b0;
            st    <= arm_for(pwm_lvl);
            cnt   <= '0;
          end
        end
        SQ_ARM_LS: begin
          if (pwm_lvl != LV_LOW) begin
            st  <= arm_for(pwm_lvl);
            cnt <= '0;
          end else if (!hs_dis) begin
            cnt <= '0;
          end else if (cnt == LS_LAST) begin
            st    <= SQ_LS;
            cnt   <= '0;
            ls_on <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SQ_LS: begin
          if (pwm_lvl != LV_LOW) begin
            ls_on <= 1'b0;
            st    <= arm_for(pwm_lvl);
            cnt   <= '0;
          end
        end
        default: begin
          st    <= SQ_IDLE;
          cnt   <= '0;
          hs_on <= 1'b0;
          ls_on <= 1'b0;
        end
      endcase
    end
  end

  // R9
  excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(hs_on && ls_on));

  // R6
  hs_fb_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_on) |-> ($past(ls_dis) && $past(pwm_lvl) == LV_HIGH && !$past(ls_on)));

  // R7
  ls_fb_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_on) |-> ($past(hs_dis) && $past(pwm_lvl) == LV_LOW && !$past(hs_on)));

  // R8
  mid_off_chk: assert property (@(posedge clk) disable iff (rst)
    (pwm_lvl == LV_MID) |=> (!hs_on && !ls_on));

endmodule

// File: rtl/nol_gate_ctrl.sv
module nol_gate_ctrl
  import nol_pkg::*;
#(
  parameter int SETTLE_CYC = 500,
  parameter int DLY_HS     = 4,
  parameter int DLY_LS     = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] pwm_code,
  input  logic [1:0] en_code,
  input  logic       supply_low,
  input  logic       hs_dis,
  input  logic       ls_dis,
  output logic       hs_on,
  output logic       ls_on
);

  lvl_t pwm_lvl;
  logic enabled;
  logic run;
  logic ready;

  nol_input_qual u_qual (
    .pwm_code   (pwm_code),
    .en_code    (en_code),
    .supply_low (supply_low),
    .pwm_lvl    (pwm_lvl),
    .enabled    (enabled),
    .run        (run)
  );

  nol_blank #(.SETTLE_CYC(SETTLE_CYC)) u_blank (
    .clk     (clk),
    .rst     (rst),
    .enabled (enabled),
    .ready   (ready)
  );

  nol_seq #(.DLY_HS(DLY_HS), .DLY_LS(DLY_LS)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .go      (run && ready),
    .pwm_lvl (pwm_lvl),
    .hs_dis  (hs_dis),
    .ls_dis  (ls_dis),
    .hs_on   (hs_on),
    .ls_on   (ls_on)
  );

  // R2
  lockout_off_chk: assert property (@(posedge clk) disable iff (rst)
    supply_low |=> (!hs_on && !ls_on));

  // R3
  en_low_off_chk: assert property (@(posedge clk) disable iff (rst)
    (en_code == 2'b00) |=> (!hs_on && !ls_on));

  // R4
  brake_off_chk: assert property (@(posedge clk) disable iff (rst)
    (en_code == 2'b01) |=> (!hs_on && !ls_on));

  // R1
  settle_off_chk: assert property (@(posedge clk) disable iff (rst)
    !ready |=> (!hs_on && !ls_on));

endmodule

// File: tb/sim_nol_gate_ctrl.sv
module sim_nol_gate_ctrl;

  localparam int S  = 10;
  localparam int DH = 3;
  localparam int DL = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] pwm_code = 2'b00;
  logic [1:0] en_code = 2'b10;
  logic       supply_low = 1'b0;
  logic       hs_dis = 1'b1;
  logic       ls_dis = 1'b1;
  logic       hs_on;
  logic       ls_on;

  int checks = 0;
  int fails  = 0;
  int edges  = 0;

  typedef struct {
    int    due;
    bit    hs;
    bit    ls;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t cur;

  nol_gate_ctrl #(.SETTLE_CYC(S), .DLY_HS(DH), .DLY_LS(DL)) u0 (
    .clk        (clk),
    .rst        (rst),
    .pwm_code   (pwm_code),
    .en_code    (en_code),
    .supply_low (supply_low),
    .hs_dis     (hs_dis),
    .ls_dis     (ls_dis),
    .hs_on      (hs_on),
    .ls_on      (ls_on)
  );

  always #5 clk = ~clk;

  always @(posedge clk) edges <= edges + 1;

  // Monitor: pops due expectations and checks the overlap invariant.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == edges) begin
      cur = q.pop_front();
      checks++;
      if (hs_on !== cur.hs || ls_on !== cur.ls) begin
        fails++;
        $display("FAIL %s edge %0d: actual hs=%b ls=%b expected hs=%b ls=%b",
                 cur.tag, edges, hs_on, ls_on, cur.hs, cur.ls);
      end
    end
    if (!rst) begin
      checks++;
      if (hs_on && ls_on) begin
        fails++;
        $display("FAIL R9 edge %0d: actual hs=1 ls=1 expected not both", edges);
      end
    end
  end

  task automatic drive(input logic [1:0] p, input logic [1:0] e,
                       input logic sl, input logic hd, input logic ld);
    @(negedge clk);
    pwm_code   = p;
    en_code    = e;
    supply_low = sl;
    hs_dis     = hd;
    ls_dis     = ld;
  endtask

  task automatic expect_at(input int k, input bit h, input bit l, input string tag);
    exp_t it;
    it.due = edges + k;
    it.hs  = h;
    it.ls  = l;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual run not finished expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: release reset with enable already high; blank then low side
    rst = 1'b0;
    expect_at(1, 0, 0, "R1");
    expect_at(S, 0, 0, "R1");
    expect_at(S + DL, 0, 0, "R1");
    expect_at(S + DL + 1, 0, 1, "R5");
    wait_cyc(S + DL + 2);

    // R3: disable, then enable with PWM high; PWM ignored during blank
    drive(2'b10, 2'b00, 0, 1, 1);
    expect_at(1, 0, 0, "R3");
    wait_cyc(3);
    drive(2'b10, 2'b10, 0, 1, 1);
    expect_at(S, 0, 0, "R3");
    expect_at(S + DH, 0, 0, "R3");
    expect_at(S + DH + 1, 1, 0, "R5");
    wait_cyc(S + DH + 2);

    // R7: high to low, hs_dis already high
    drive(2'b00, 2'b10, 0, 1, 1);
    expect_at(1, 0, 0, "R7");
    expect_at(DL, 0, 0, "R7");
    expect_at(DL + 1, 0, 1, "R7");
    wait_cyc(DL + 2);

    // R6: low to high with ls_dis held low, then a dropout in the count
    drive(2'b10, 2'b10, 0, 1, 0);
    expect_at(1, 0, 0, "R6");
    expect_at(6, 0, 0, "R6");
    wait_cyc(6);
    drive(2'b10, 2'b10, 0, 1, 1);
    drive(2'b10, 2'b10, 0, 1, 0);
    drive(2'b10, 2'b10, 0, 1, 1);
    expect_at(1, 0, 0, "R6");
    expect_at(DH - 1, 0, 0, "R6");
    expect_at(DH, 1, 0, "R6");
    wait_cyc(DH + 1);

    // R8: mid clears and stays off
    drive(2'b01, 2'b10, 0, 1, 1);
    expect_at(1, 0, 0, "R8");
    expect_at(10, 0, 0, "R8");
    wait_cyc(10);
    // R8: from mid to high the full delay still applies
    drive(2'b10, 2'b10, 0, 1, 1);
    expect_at(DH, 0, 0, "R8");
    expect_at(DH + 1, 1, 0, "R8");
    wait_cyc(DH + 2);
    // R8: single-cycle mid pulse
    drive(2'b01, 2'b10, 0, 1, 1);
    expect_at(1, 0, 0, "R8");
    drive(2'b10, 2'b10, 0, 1, 1);
    expect_at(DH, 0, 0, "R8");
    expect_at(DH + 1, 1, 0, "R8");
    wait_cyc(DH + 2);

    // R4: braking while high side is on, then back to high without blank
    drive(2'b10, 2'b01, 0, 1, 1);
    expect_at(1, 0, 0, "R4");
    expect_at(5, 0, 0, "R4");
    wait_cyc(5);
    drive(2'b10, 2'b10, 0, 1, 1);
    expect_at(DH, 0, 0, "R4");
    expect_at(DH + 1, 1, 0, "R4");
    wait_cyc(DH + 2);

    // R10: abort a low-side delay with enable low, then re-blank
    drive(2'b00, 2'b10, 0, 1, 1);
    expect_at(1, 0, 0, "R10");
    wait_cyc(2);
    drive(2'b00, 2'b00, 0, 1, 1);
    expect_at(1, 0, 0, "R10");
    expect_at(DL + 2, 0, 0, "R10");
    wait_cyc(DL + 3);
    drive(2'b00, 2'b10, 0, 1, 1);
    expect_at(S, 0, 0, "R3");
    expect_at(S + DL + 1, 0, 1, "R3");
    wait_cyc(S + DL + 2);

    // R2: lockout while low side on, then release and re-blank
    drive(2'b00, 2'b10, 1, 1, 1);
    expect_at(1, 0, 0, "R2");
    expect_at(4, 0, 0, "R2");
    wait_cyc(4);
    drive(2'b00, 2'b10, 0, 1, 1);
    expect_at(S, 0, 0, "R2");
    expect_at(S + DL, 0, 0, "R2");
    expect_at(S + DL + 1, 0, 1, "R2");
    wait_cyc(S + DL + 2);

    // R8: unused code behaves as mid
    drive(2'b11, 2'b10, 0, 1, 1);
    expect_at(1, 0, 0, "R8");
    expect_at(6, 0, 0, "R8");
    wait_cyc(7);

    // R9: random stimulus, overlap checked every cycle by the monitor
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      drive(2'($urandom), (r < 4'd12) ? 2'b10 : 2'($urandom),
            ($urandom % 64) == 0, 1'($urandom), 1'($urandom));
    end

    wait_cyc(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule